// File: doc/BRIEF.md
# Vector Predicate Mask Builder

This block builds the source and destination predicate masks that a vector instruction needs before it issues. An issue stage hands it a request made of a predicate mode, two 3-bit selector fields (one for the source mask, one for the destination mask) and the vector length. The block then works through the required register-file reads and returns both 64-bit masks on a second valid/ready handshake. It holds the masks in registers until the consumer takes them.

There are three predicate modes:

- **No predication.** Both masks are all ones.
- **Integer predication.** Each selector names one integer register, together with an optional complement or a single-bit "unary" form. The block makes one read per mask.
- **Condition predication.** The block makes one 4-bit condition-field read per vector element. It picks one bit of each field, optionally inverts it, and assembles the mask one bit per element.

Both register files sit outside the block and answer a read on the clock after it is requested.

The controller has seven states:

- **IDLE**: waits for a request.
- **PICK**: starts the work for the current mask.
- **INT_RD** and **INT_CAP**: issue and capture an integer read.
- **CR_RD** and **CR_CAP**: issue and capture a condition-field read.
- **DONE**: offers the result.

Its transitions are:

- IDLE to DONE on a request with no predication.
- IDLE to PICK on a request with predication.
- PICK to INT_RD, PICK to CR_RD, or PICK back to PICK when a mask needs no read and the source phase hands over to the destination phase.
- PICK to DONE when the destination mask needs no read.
- INT_RD to INT_CAP.
- INT_CAP to PICK or to DONE.
- CR_RD to CR_CAP.
- CR_CAP back to CR_RD for the next element, or on to PICK or DONE.
- DONE to IDLE once the consumer is ready.

Top module: `vpm_top`

## Requirements
- R1: `req_ready` is high only in IDLE. Once the masks are complete, `mask_valid` rises and stays high, with both masks stable, until `mask_ready` is sampled high. The block is then back in IDLE on the next cycle.
- R2: Mode code 0 (no predication) and the reserved code 3 give all-ones source and destination masks and cause no register read.
- R3: In integer mode (code 1) the selector codes are: 0 = no predication (all ones, no read), 1 = unary on register 3, 2 = register 3, 3 = register 3 complemented, 4 = register 10, 5 = register 10 complemented, 6 = register 30, 7 = register 30 complemented.
- R4: A direct integer selection gives the register value. A complemented selection gives its bitwise complement.
- R5: The unary selection gives a mask with exactly one set bit, at the position given by bits [5:0] of register 3.
- R6: Each register read is enabled for a single cycle, and its data is taken on the following clock. An integer request that needs k reads presents `mask_valid` 2 + 2k cycles after acceptance.
- R7: In condition mode (code 2) the block makes exactly one condition-field read per element 0 to VL-1, per mask. For element i the one-hot enable sits at bit CR_FIELDS-1-(i+CR_OFFS).
- R8: In condition mode, selector bits [2:1] give k, and bit [0] inverts. Mask bit i equals field bit (3-k) of element i's field, XOR the invert bit. The resulting code pairs are 0/1 = LT/GE, 2/3 = GT/LE, 4/5 = EQ/NE, 6/7 = SO/NS.
- R9: In condition mode, mask bits at positions VL and above are zero. A VL of 0 finishes with both masks zero and no reads.
- R10: All reads for the source mask come before any read for the destination mask.
- R11: After synchronous reset the block is in IDLE with `req_ready` high, `mask_valid` low and both masks all ones.
- R12: A request presented while the block is busy is not accepted and does not alter the masks being built.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_mode | input | 2 | Predicate mode: 0 none, 1 integer, 2 condition, 3 reserved |
| req_src_sel | input | 3 | Source-mask selector |
| req_dst_sel | input | 3 | Destination-mask selector |
| req_vl | input | 7 | Vector length, 0 to MAX_VL |
| gpr_ren | output | 1 | Integer register read enable |
| gpr_addr | output | 5 | Integer register number |
| gpr_rdata | input | 64 | Integer read data, one cycle after enable |
| crf_ren | output | 128 | One-hot condition-field read enable |
| crf_rdata | input | 4 | Condition-field read data, one cycle after enable |
| mask_valid | output | 1 | Masks complete |
| mask_ready | input | 1 | Consumer takes the masks |
| src_mask | output | 64 | Source predicate mask |
| dst_mask | output | 64 | Destination predicate mask |

## Verification
The hardest situation to reach is a condition-mode mask whose bits come from many distinct field reads, each landing at the right element, with nothing left above VL. The bench models both register files, with contents computed arithmetically and changed between requests. It sweeps all 64 source/destination selector pairs in both integer and condition modes. It then drives VL through 0, 1, 63 and 64. To exercise rejection while busy, it keeps presenting a different request for the whole duration of a run. To exercise the output hold, it delays the consumer's ready for several cycles.

// File: rtl/vpm_pkg.sv
package vpm_pkg;

    typedef enum logic [1:0] {
        PM_NONE = 2'd0,
        PM_INT  = 2'd1,
        PM_CR   = 2'd2,
        PM_RSVD = 2'd3
    } pmode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PICK,
        ST_INT_RD,
        ST_INT_CAP,
        ST_CR_RD,
        ST_CR_CAP,
        ST_DONE
    } st_e;

    typedef struct packed {
        logic [4:0] rnum;
        logic       inv;
        logic       unary;
        logic       none;
    } int_sel_t;

endpackage

// File: rtl/vpm_int_dec.sv
module vpm_int_dec
    import vpm_pkg::*;
(
    input  logic [2:0] sel,
    output int_sel_t   dec
);
    always_comb begin
        dec = '{rnum: 5'd0, inv: 1'b0, unary: 1'b0, none: 1'b0};
        unique case (sel)
            3'd0: dec.none = 1'b1;
            3'd1: begin dec.rnum = 5'd3;  dec.unary = 1'b1; end
            3'd2: dec.rnum = 5'd3;
            3'd3: begin dec.rnum = 5'd3;  dec.inv = 1'b1; end
            3'd4: dec.rnum = 5'd10;
            3'd5: begin dec.rnum = 5'd10; dec.inv = 1'b1; end
            3'd6: dec.rnum = 5'd30;
            3'd7: begin dec.rnum = 5'd30; dec.inv = 1'b1; end
            default: dec.none = 1'b1;
        endcase
    end
endmodule

// File: rtl/vpm_cr_dec.sv
module vpm_cr_dec (
    input  logic [2:0] sel,
    output logic [1:0] bit_k,
    output logic       inv
);
    // paired codes share the bit index and differ only in the inversion
    always_comb begin
        bit_k = sel[2:1];
        inv   = sel[0];
    end
endmodule

// File: rtl/vpm_mask_merge.sv
module vpm_mask_merge
    import vpm_pkg::*;
#(
    parameter int W = 64
) (
    input  int_sel_t               isel,
    input  logic [W-1:0]           gpr_word,
    input  logic [3:0]             cr_field,
    input  logic [1:0]             cr_k,
    input  logic                   cr_inv,
    input  logic [$clog2(W)-1:0]   idx,
    input  logic [W-1:0]           cur,
    output logic [W-1:0]           int_mask,
    output logic [W-1:0]           cr_mask
);
    localparam int IW = $clog2(W);

    logic cr_bit;

    always_comb begin
        if (isel.none)
            int_mask = '1;
        else if (isel.unary)
            int_mask = {{(W-1){1'b0}}, 1'b1} << gpr_word[IW-1:0];
        else if (isel.inv)
            int_mask = ~gpr_word;
        else
            int_mask = gpr_word;
    end

    assign cr_bit = cr_field[2'd3 - cr_k] ^ cr_inv;

    for (genvar i = 0; i < W; i++) begin : g_ins
        assign cr_mask[i] = (idx == IW'(i)) ? cr_bit : cur[i];
    end
endmodule

// File: rtl/vpm_top.sv
module vpm_top
    import vpm_pkg::*;
#(
    parameter int W         = 64,
    parameter int MAX_VL    = 64,
    parameter int CR_FIELDS = 128,
    parameter int CR_OFFS   = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [1:0]            req_mode,
    input  logic [2:0]            req_src_sel,
    input  logic [2:0]            req_dst_sel,
    input  logic [6:0]            req_vl,
    output logic                  gpr_ren,
    output logic [4:0]            gpr_addr,
    input  logic [W-1:0]          gpr_rdata,
    output logic [CR_FIELDS-1:0]  crf_ren,
    input  logic [3:0]            crf_rdata,
    output logic                  mask_valid,
    input  logic                  mask_ready,
    output logic [W-1:0]          src_mask,
    output logic [W-1:0]          dst_mask
);
    localparam int IW  = $clog2(W);
    localparam int VLW = 7;
    localparam int CRW = $clog2(CR_FIELDS);

    st_e            st_q, st_d;
    pmode_e         mode_q;
    logic [2:0]     ssel_q, dsel_q, cur_sel;
    logic [VLW-1:0] vl_q;
    logic           phase_q, phase_d;
    logic [IW-1:0]  idx_q, idx_d;
    logic [W-1:0]   src_q, dst_q, cur_mask;
    logic           wr_en, both_ones, fin, last_el;
    logic [W-1:0]   wr_val;
    int_sel_t       isel;
    logic [1:0]     cr_k;
    logic           cr_inv;
    logic [W-1:0]   int_val, cr_val;
    logic [CRW-1:0] cr_pos;

    assign cur_sel  = phase_q ? dsel_q : ssel_q;
    assign cur_mask = phase_q ? dst_q : src_q;
    assign last_el  = (VLW'(idx_q) + VLW'(1)) == vl_q;
    assign cr_pos   = CRW'(CR_FIELDS - 1) - (CRW'(idx_q) + CRW'(CR_OFFS));

    vpm_int_dec u_idec (.sel(cur_sel), .dec(isel));
    vpm_cr_dec  u_cdec (.sel(cur_sel), .bit_k(cr_k), .inv(cr_inv));
    vpm_mask_merge #(.W(W)) u_merge (
        .isel(isel), .gpr_word(gpr_rdata), .cr_field(crf_rdata),
        .cr_k(cr_k), .cr_inv(cr_inv), .idx(idx_q), .cur(cur_mask),
        .int_mask(int_val), .cr_mask(cr_val)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // transitions and mask write control
    always_comb begin
        st_d      = st_q;
        phase_d   = phase_q;
        idx_d     = idx_q;
        wr_en     = 1'b0;
        wr_val    = '0;
        both_ones = 1'b0;
        fin       = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_mode == PM_INT || req_mode == PM_CR) begin
                        st_d = ST_PICK;
                    end else begin
                        st_d      = ST_DONE;
                        both_ones = 1'b1;
                    end
                end
            end
            ST_PICK: begin
                if (mode_q == PM_INT) begin
                    if (isel.none) begin
                        wr_en  = 1'b1;
                        wr_val = '1;
                        fin    = 1'b1;
                    end else begin
                        st_d = ST_INT_RD;
                    end
                end else begin
                    wr_en  = 1'b1;
                    wr_val = '0;
                    idx_d  = '0;
                    if (vl_q == '0) fin = 1'b1;
                    else            st_d = ST_CR_RD;
                end
            end
            ST_INT_RD:  st_d = ST_INT_CAP;
            ST_INT_CAP: begin
                wr_en  = 1'b1;
                wr_val = int_val;
                fin    = 1'b1;
            end
            ST_CR_RD:   st_d = ST_CR_CAP;
            ST_CR_CAP: begin
                wr_en  = 1'b1;
                wr_val = cr_val;
                if (last_el) begin
                    fin = 1'b1;
                end else begin
                    idx_d = idx_q + IW'(1);
                    st_d  = ST_CR_RD;
                end
            end
            ST_DONE: if (mask_ready) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
        if (fin) begin
            if (!phase_q) begin
                phase_d = 1'b1;
                st_d    = ST_PICK;
            end else begin
                st_d = ST_DONE;
            end
        end
    end

    // request capture and mask registers
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= PM_NONE;
            ssel_q  <= '0;
            dsel_q  <= '0;
            vl_q    <= '0;
            phase_q <= 1'b0;
            idx_q   <= '0;
            src_q   <= '1;
            dst_q   <= '1;
        end else begin
            idx_q <= idx_d;
            if (st_q == ST_IDLE && req_valid) begin
                mode_q  <= pmode_e'(req_mode);
                ssel_q  <= req_src_sel;
                dsel_q  <= req_dst_sel;
                vl_q    <= req_vl;
                phase_q <= 1'b0;
            end else begin
                phase_q <= phase_d;
            end
            if (both_ones) begin
                src_q <= '1;
                dst_q <= '1;
            end else if (wr_en) begin
                if (phase_q) dst_q <= wr_val;
                else         src_q <= wr_val;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready  = (st_q == ST_IDLE);
        mask_valid = (st_q == ST_DONE);
        gpr_ren    = (st_q == ST_INT_RD);
        gpr_addr   = isel.rnum;
        crf_ren    = (st_q == ST_CR_RD) ? ({{(CR_FIELDS-1){1'b0}}, 1'b1} << cr_pos) : '0;
        src_mask   = src_q;
        dst_mask   = dst_q;
    end

    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        mask_valid && !mask_ready |=> mask_valid && $stable(src_mask) && $stable(dst_mask));
    p_excl_r12: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mask_valid && !gpr_ren && crf_ren == '0);
    p_none_r2: assert property (@(posedge clk) disable iff (rst)
        mask_valid && (mode_q == PM_NONE || mode_q == PM_RSVD) |-> (&src_mask) && (&dst_mask));
    p_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        gpr_ren |=> !gpr_ren);
    p_crpulse_r7: assert property (@(posedge clk) disable iff (rst)
        (crf_ren != '0) |=> (crf_ren == '0));
    p_onehot_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(crf_ren));
    p_tail_r9: assert property (@(posedge clk) disable iff (rst)
        mask_valid && mode_q == PM_CR && vl_q < VLW'(MAX_VL) |->
            ((src_mask >> vl_q) == '0) && ((dst_mask >> vl_q) == '0));
    p_ports_r10: assert property (@(posedge clk) disable iff (rst)
        !(gpr_ren && crf_ren != '0));
endmodule

// File: tb/sim_vpm_top.sv
module sim_vpm_top;
    localparam int  W = 64;
    localparam int  CRF = 128;
    localparam int  CRO = 32;
    localparam time TCLK = 10ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, mask_ready = 1'b0;
    logic [1:0] req_mode = '0;
    logic [2:0] req_src_sel = '0, req_dst_sel = '0;
    logic [6:0] req_vl = '0;
    logic req_ready, gpr_ren, mask_valid;
    logic [4:0] gpr_addr;
    logic [W-1:0] gpr_rdata = '0;
    logic [CRF-1:0] crf_ren;
    logic [3:0] crf_rdata = '0;
    logic [W-1:0] src_mask, dst_mask;

    int checks = 0, errors = 0, cyc = 0;
    logic [31:0] seed = 32'h1234_5678;
    logic model_clr = 1'b0;
    int gpr_reads = 0, cr_reads = 0, cr_bad = 0;
    logic [4:0] addr0 = '0, addr1 = '0;
    int exp_vl = 0;

    always #(TCLK/2) clk = ~clk;

    vpm_top u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_mode(req_mode), .req_src_sel(req_src_sel), .req_dst_sel(req_dst_sel),
        .req_vl(req_vl), .gpr_ren(gpr_ren), .gpr_addr(gpr_addr), .gpr_rdata(gpr_rdata),
        .crf_ren(crf_ren), .crf_rdata(crf_rdata), .mask_valid(mask_valid),
        .mask_ready(mask_ready), .src_mask(src_mask), .dst_mask(dst_mask)
    );

    function automatic logic [63:0] gv(input logic [4:0] a);
        gv = {(32'(a) * 32'h9E37_79B9) ^ seed, (seed * 32'h85EB_CA6B) + 32'(a)};
    endfunction

    function automatic logic [3:0] cv(input int p);
        logic [31:0] t;
        t = 32'(p) * 32'd7 + seed[7:0] * 32'd3;
        cv = t[3:0] ^ 4'(p >> 2);
    endfunction

    // register file models: data one clock after the enable
    always @(posedge clk) begin
        if (model_clr) begin
            gpr_reads <= 0;
            cr_reads  <= 0;
            cr_bad    <= 0;
        end else begin
            if (gpr_ren) begin
                gpr_rdata <= gv(gpr_addr);
                if (gpr_reads == 0) addr0 <= gpr_addr;
                if (gpr_reads == 1) addr1 <= gpr_addr;
                gpr_reads <= gpr_reads + 1;
            end
            if (crf_ren != '0) begin
                if ($countones(crf_ren) != 1 || exp_vl == 0 ||
                    !crf_ren[CRF - 1 - ((cr_reads % exp_vl) + CRO)])
                    cr_bad <= cr_bad + 1;
                for (int p = 0; p < CRF; p++)
                    if (crf_ren[p]) crf_rdata <= cv(p);
                cr_reads <= cr_reads + 1;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_int(input logic [2:0] s);
        case (s)
            3'd0: exp_int = '1;
            3'd1: exp_int = 64'd1 << gv(5'd3)[5:0];
            3'd2: exp_int = gv(5'd3);
            3'd3: exp_int = ~gv(5'd3);
            3'd4: exp_int = gv(5'd10);
            3'd5: exp_int = ~gv(5'd10);
            3'd6: exp_int = gv(5'd30);
            default: exp_int = ~gv(5'd30);
        endcase
    endfunction

    function automatic logic [4:0] reg_of(input logic [2:0] s);
        reg_of = (s <= 3'd3) ? 5'd3 : (s <= 3'd5) ? 5'd10 : 5'd30;
    endfunction

    function automatic logic [63:0] exp_cr(input logic [2:0] s, input int vl);
        logic [63:0] m;
        logic [3:0] d;
        m = '0;
        for (int i = 0; i < vl; i++) begin
            d = cv(CRF - 1 - (i + CRO));
            m[i] = d[3 - int'(s[2:1])] ^ s[0];
        end
        exp_cr = m;
    endfunction

    task automatic run_op(input logic [1:0] md, input logic [2:0] s, input logic [2:0] d,
                          input int vl, input bit hold, input bit junk);
        logic [63:0] es, ed;
        int nr, n, busy_rdy;
        string tg;
        @(negedge clk);
        seed = seed * 32'd1664525 + 32'd1013904223;
        exp_vl = vl;
        model_clr = 1'b1;
        @(negedge clk);
        model_clr = 1'b0;
        if (md == 2'd1) begin
            es = exp_int(s); ed = exp_int(d);
            nr = int'(s != 0) + int'(d != 0);
            tg = "R4";
        end else if (md == 2'd2) begin
            es = exp_cr(s, vl); ed = exp_cr(d, vl);
            nr = 2 * vl;
            tg = "R8";
        end else begin
            es = '1; ed = '1; nr = 0;
            tg = "R2";
        end
        check(req_ready === 1'b1, "R1 ready in idle", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_mode = md; req_src_sel = s; req_dst_sel = d; req_vl = 7'(vl);
        @(negedge clk);
        if (junk) begin
            req_mode = (md == 2'd1) ? 2'd2 : 2'd1;
            req_src_sel = ~s; req_dst_sel = ~d; req_vl = 7'd33;
        end else begin
            req_valid = 1'b0;
        end
        n = 0; busy_rdy = 0;
        while (!mask_valid && n < 1000) begin
            if (req_ready) busy_rdy++;
            @(negedge clk);
            n++;
        end
        check(n < 1000, "R1 mask_valid timeout", 64'(n), 64'd0);
        check(src_mask === es, {tg, " src mask"}, src_mask, es);
        check(dst_mask === ed, {tg, " dst mask"}, dst_mask, ed);
        if (junk) check(busy_rdy == 0, "R12 ready while busy", 64'(busy_rdy), 64'd0);
        if (md == 2'd1) begin
            check(gpr_reads == nr, "R6 integer read count", 64'(gpr_reads), 64'(nr));
            check(n == 2 + 2 * nr, "R6 latency", 64'(n), 64'(2 + 2 * nr));
            if (s != 0) check(addr0 === reg_of(s), "R3 first address (R10 src first)", 64'(addr0), 64'(reg_of(s)));
            if (s != 0 && d != 0) check(addr1 === reg_of(d), "R10 second address", 64'(addr1), 64'(reg_of(d)));
            if (s == 3'd1) check($countones(src_mask) == 1, "R5 unary one bit", src_mask, es);
        end else if (md == 2'd2) begin
            check(cr_reads == nr, "R7 field read count", 64'(cr_reads), 64'(nr));
            check(cr_bad == 0, "R7 enable position", 64'(cr_bad), 64'd0);
            if (vl < 64) check((src_mask >> vl) == 0, "R9 tail zero", src_mask, es);
        end else begin
            check(gpr_reads == 0 && cr_reads == 0, "R2 no reads", 64'(gpr_reads + cr_reads), 64'd0);
        end
        if (hold) begin
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check(mask_valid === 1'b1 && src_mask === es && dst_mask === ed,
                      "R1 hold until ready", src_mask, es);
            end
        end
        req_valid = 1'b0;
        mask_ready = 1'b1;
        @(negedge clk);
        mask_ready = 1'b0;
        check(req_ready === 1'b1 && mask_valid === 1'b0, "R1 back to idle", 64'(req_ready), 64'd1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(req_ready === 1'b1, "R11 ready after reset", 64'(req_ready), 64'd1);
        check(mask_valid === 1'b0, "R11 no valid after reset", 64'(mask_valid), 64'd0);
        check(src_mask === '1 && dst_mask === '1, "R11 masks all ones", src_mask, '1);

        run_op(2'd0, 3'd2, 3'd5, 9, 1'b0, 1'b0);
        run_op(2'd3, 3'd7, 3'd1, 0, 1'b0, 1'b0);
        for (int s = 0; s < 8; s++)
            for (int d = 0; d < 8; d++)
                run_op(2'd1, 3'(s), 3'(d), 4, 1'b0, 1'b0);
        for (int k = 0; k < 6; k++) run_op(2'd1, 3'd1, 3'd1, 1, 1'b0, 1'b0);
        for (int s = 0; s < 8; s++)
            for (int d = 0; d < 8; d++)
                run_op(2'd2, 3'(s), 3'(d), 7, 1'b0, 1'b0);
        run_op(2'd2, 3'd0, 3'd5, 0, 1'b0, 1'b0);
        run_op(2'd2, 3'd3, 3'd6, 1, 1'b0, 1'b0);
        run_op(2'd2, 3'd4, 3'd1, 63, 1'b0, 1'b0);
        run_op(2'd2, 3'd7, 3'd2, 64, 1'b0, 1'b0);
        run_op(2'd1, 3'd3, 3'd6, 4, 1'b1, 1'b0);
        run_op(2'd2, 3'd5, 3'd0, 12, 1'b1, 1'b0);
        run_op(2'd1, 3'd2, 3'd7, 4, 1'b0, 1'b1);
        run_op(2'd2, 3'd1, 3'd4, 20, 1'b0, 1'b1);
        run_op(2'd0, 3'd1, 3'd1, 5, 1'b1, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule